// File: doc/BRIEF.md
# Chained Dual-Channel Timestamp Counter

The block forms a free-running timestamp of twice the channel width out of two counter channels. The low channel counts a prescaled copy of the system clock. The prescale factor is picked from four settings. The low channel also produces a square wave from two compare points: it goes high when the count reaches zero and low when it reaches half of its range.

A routing register can select that square wave as the clock source of the high channel. The high channel then advances once per full turn of the low channel. Software builds the timestamp by placing the high count above the low count. Because the two halves are read one after the other, software reads high, then low, then high again, and retries until the two high reads agree.

A single write of the sync command zeroes both channels and the prescaler on the same clock edge, so the two halves restart aligned. When the `WIDE` parameter is set, channel 0 alone is built at double width and gives the whole timestamp. Channel 1 is then absent. Each channel has a two-state controller with the states CH_IDLE and CH_RUN. The START transition goes from CH_IDLE to CH_RUN on a start command that has no stop bit. The STOP transition goes from CH_RUN to CH_IDLE on any stop command.

Top module: `chained_timestamp`

## Requirements
- R1: After reset, both counts read 0, the prescale index reads 0, the routing bit reads 0, `wave_out[0]` is 1, and channel 0 does not count until it is started.
- R2: A write to a channel command address (0 for channel 0, 3 for channel 1) starts the channel when bit 0 is set. It stops the channel when bit 1 is set, and stop wins when both bits are set. A stopped channel holds its count.
- R3: The prescale index sits at address 1, bits [1:0], and is readable there. While running, channel 0 advances once every 2, 8, 32 or 128 clock cycles for index 0, 1, 2 or 3. The count advances only by one, except when a sync zeroes it.
- R4: Writing 1 to bit 0 of address 6 zeroes both counts and the prescaler on the same edge. It leaves the run state of each channel unchanged, so N cycles later a running channel 0 reads floor(N / divisor).
- R5: `wave_out[0]` is 1 exactly while the channel 0 count is below 2^(width-1). It rises on the tick that brings the count to zero and falls on the tick that brings it to the half point.
- R6: When bit 0 of address 5 is 1, channel 1 advances one cycle after each rising edge of `wave_out[0]`. When that bit is 0, channel 1 holds.
- R7: Both channels wrap from all-ones to zero and keep counting.
- R8: The timestamp is the channel 1 count (address 4) placed above the channel 0 count (address 2). Reading high, then low, then high again, and retrying until the two high reads agree, gives values that never decrease.
- R9: With `WIDE` = 1, channel 0 counts at double width by itself. Address 4 reads 0 whatever is written to address 3, and `wave_out[1]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 2 | Write data |
| rd_addr | input | 3 | Read address (combinational read) |
| rd_data | output | 2*CH_W | Read data |
| wave_out | output | 2 | Square-wave outputs of channel 0 and channel 1 |

## Verification
The assertions assume that the register interface is the only thing that moves a count. They also assume that a write is held for exactly one clock, with stable address and data. The bench respects this by driving every write on the falling edge and holding it for one cycle only. It reads the combinational port a moment after the falling edge. The channel width is reduced for the bench so that wraps of the low half occur within a few hundred cycles. The wide-mode instance uses the same reduced width.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam int AW   = 3;
    localparam int WD_W = 2;

    localparam logic [AW-1:0] A_C0_CMD = 3'd0;
    localparam logic [AW-1:0] A_DIV    = 3'd1;
    localparam logic [AW-1:0] A_C0_CNT = 3'd2;
    localparam logic [AW-1:0] A_C1_CMD = 3'd3;
    localparam logic [AW-1:0] A_C1_CNT = 3'd4;
    localparam logic [AW-1:0] A_ROUTE  = 3'd5;
    localparam logic [AW-1:0] A_SYNC   = 3'd6;

    localparam int BIT_START = 0;
    localparam int BIT_STOP  = 1;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } chan_state_e;
endpackage

// File: rtl/ts_prescaler.sv
module ts_prescaler #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [IDX_W-1:0] div_idx,
    output logic             tick
);
    // largest divisor is 2 << (2*(2^IDX_W-1)); one spare bit keeps it representable
    localparam int PC_W = 2 * ((1 << IDX_W) - 1) + 2;

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] limit;

    always_comb begin
        limit = (PC_W'(2) << (2 * div_idx)) - PC_W'(1);
        tick  = run && (pcnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clear || !run || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + PC_W'(1);
    end
endmodule

// File: rtl/ts_channel.sv
module ts_channel
    import ts_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         stop,
    input  logic         sync,
    input  logic         tick,
    output logic         running,
    output logic [W-1:0] cnt,
    output logic         wave
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    chan_state_e state, state_nx;
    logic [W-1:0] cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CH_IDLE;
        else
            state <= state_nx;
    end

    // transitions: START (idle->run), STOP (run->idle, stop has priority)
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: if (start && !stop) state_nx = CH_RUN;
            CH_RUN:  if (stop)           state_nx = CH_IDLE;
        endcase
    end

    assign running = (state == CH_RUN);
    assign cnt_nx  = cnt + W'(1);

    // outputs: count and compare-driven wave
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            wave <= 1'b1;
        end else if (sync) begin
            cnt  <= '0;
            wave <= 1'b1;
        end else if (running && tick) begin
            cnt <= cnt_nx;
            if (cnt_nx == '0)
                wave <= 1'b1;
            else if (cnt_nx == HALF)
                wave <= 1'b0;
        end
    end
endmodule

// File: rtl/chained_timestamp.sv
module chained_timestamp
    import ts_pkg::*;
#(
    parameter int CH_W = 16,
    parameter int WIDE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [1:0]        wr_data,
    input  logic [2:0]        rd_addr,
    output logic [2*CH_W-1:0] rd_data,
    output logic [1:0]        wave_out
);
    localparam int DATA_W = 2 * CH_W;
    localparam int C0_W   = (WIDE != 0) ? DATA_W : CH_W;

    logic [1:0]      div_idx_q;
    logic            route_q;
    logic            sync;
    logic            div_wr;
    logic            c0_start, c0_stop;
    logic            run0;
    logic            tick0;
    logic [C0_W-1:0] cnt0;
    logic [CH_W-1:0] cnt1;
    logic            wave0, wave1;

    assign sync     = wr_en && (wr_addr == A_SYNC)   && wr_data[0];
    assign div_wr   = wr_en && (wr_addr == A_DIV);
    assign c0_start = wr_en && (wr_addr == A_C0_CMD) && wr_data[BIT_START];
    assign c0_stop  = wr_en && (wr_addr == A_C0_CMD) && wr_data[BIT_STOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_idx_q <= '0;
            route_q   <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_DIV)   div_idx_q <= wr_data;
            if (wr_addr == A_ROUTE) route_q   <= wr_data[0];
        end
    end

    ts_prescaler #(.IDX_W(2)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sync || div_wr),
        .run     (run0),
        .div_idx (div_idx_q),
        .tick    (tick0)
    );

    ts_channel #(.W(C0_W)) u_ch0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (c0_start),
        .stop    (c0_stop),
        .sync    (sync),
        .tick    (tick0),
        .running (run0),
        .cnt     (cnt0),
        .wave    (wave0)
    );

    generate
        if (WIDE != 0) begin : g_wide
            assign cnt1  = '0;
            assign wave1 = 1'b0;
        end else begin : g_chain
            logic wave0_q;
            logic hi_tick;
            logic c1_start, c1_stop;
            logic run1;

            assign c1_start = wr_en && (wr_addr == A_C1_CMD) && wr_data[BIT_START];
            assign c1_stop  = wr_en && (wr_addr == A_C1_CMD) && wr_data[BIT_STOP];

            // rising edge of the routed wave, seen in the system clock domain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    wave0_q <= 1'b1;
                else if (sync)
                    wave0_q <= 1'b1;
                else
                    wave0_q <= wave0;
            end
            assign hi_tick = route_q && wave0 && !wave0_q;

            ts_channel #(.W(CH_W)) u_ch1 (
                .clk     (clk),
                .rst_n   (rst_n),
                .start   (c1_start),
                .stop    (c1_stop),
                .sync    (sync),
                .tick    (hi_tick),
                .running (run1),
                .cnt     (cnt1),
                .wave    (wave1)
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_DIV:    rd_data = DATA_W'(div_idx_q);
            A_ROUTE:  rd_data = DATA_W'(route_q);
            A_C0_CNT: rd_data = DATA_W'(cnt0);
            A_C1_CNT: rd_data = DATA_W'(cnt1);
            default:  rd_data = '0;
        endcase
    end

    assign wave_out = {wave1, wave0};
endmodule

// File: rtl/ts_checker.sv
module ts_checker
    import ts_pkg::*;
#(
    parameter int CH_W = 16,
    parameter int WIDE = 0,
    parameter int C0_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [2:0]      wr_addr,
    input logic [1:0]      wr_data,
    input logic            route,
    input logic            run0,
    input logic [C0_W-1:0] cnt0,
    input logic [CH_W-1:0] cnt1,
    input logic            wave0
);
    localparam logic [C0_W-1:0] HALF0 = {1'b1, {(C0_W-1){1'b0}}};

    logic sync_now;
    assign sync_now = wr_en && (wr_addr == A_SYNC) && wr_data[0];

    AST_SYNC_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        sync_now |=> (cnt0 == '0 && cnt1 == '0));                              // R4

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_C0_CMD && wr_data == 2'b11) |=> !run0);         // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !sync_now) |=> $stable(cnt0));                               // R2

    AST_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt0 != $past(cnt0)) |-> ($past(sync_now) || cnt0 == C0_W'($past(cnt0) + 1'b1))); // R3

    AST_WAVE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        wave0 == (cnt0 < HALF0));                                              // R5

    generate
        if (WIDE != 0) begin : g_wide_chk
            AST_HIGH_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
                cnt1 == '0);                                                   // R9
        end else begin : g_chain_chk
            AST_HIGH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt1 != $past(cnt1)) |-> ($past(sync_now) ||
                    ($past(route) && cnt1 == CH_W'($past(cnt1) + 1'b1))));     // R6
            AST_UNROUTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!route && !sync_now) |=> $stable(cnt1));                      // R6
        end
    endgenerate
endmodule

bind chained_timestamp ts_checker #(
    .CH_W (CH_W),
    .WIDE (WIDE),
    .C0_W (C0_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .route   (route_q),
    .run0    (run0),
    .cnt0    (cnt0),
    .cnt1    (cnt1),
    .wave0   (wave0)
);

// File: tb/chained_timestamp_test.sv
module chained_timestamp_test;
    localparam int W  = 8;
    localparam int DW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_en_w = 1'b0;
    logic [2:0]    wr_addr = '0, wr_addr_w = '0;
    logic [1:0]    wr_data = '0, wr_data_w = '0;
    logic [2:0]    rd_addr = '0, rd_addr_w = '0;
    logic [DW-1:0] rd_data, rd_data_w;
    logic [1:0]    wave_out, wave_out_w;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    chained_timestamp #(.CH_W(W), .WIDE(0)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wave_out(wave_out));

    chained_timestamp #(.CH_W(W), .WIDE(1)) uut_wide (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_addr(wr_addr_w),
        .wr_data(wr_data_w), .rd_addr(rd_addr_w), .rd_data(rd_data_w), .wave_out(wave_out_w));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_w(input logic [2:0] a, input logic [1:0] d);
        @(negedge clk);
        wr_en_w = 1'b1; wr_addr_w = a; wr_data_w = d;
        @(negedge clk);
        wr_en_w = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic rd_w(input logic [2:0] a, output logic [DW-1:0] v);
        rd_addr_w = a;
        #1 v = rd_data_w;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_ts(output logic [DW-1:0] ts);
        logic [DW-1:0] h1, lo, h2;
        do begin
            rd(3'd4, h1); @(negedge clk);
            rd(3'd2, lo); @(negedge clk);
            rd(3'd4, h2); @(negedge clk);
        end while (h1 != h2);
        ts = {h1[W-1:0], lo[W-1:0]};
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        rd(3'd2, v); check("R1 low count", v, 0);
        rd(3'd4, v); check("R1 high count", v, 0);
        rd(3'd1, v); check("R1 prescale index", v, 0);
        rd(3'd5, v); check("R1 routing bit", v, 0);
        check("R1 wave", wave_out[0], 1);
        idle(10);
        rd(3'd2, v); check("R1 stopped after reset", v, 0);
    endtask

    task automatic t_start_stop;
        logic [DW-1:0] a, b;
        wr(3'd0, 2'b01);
        wr(3'd3, 2'b01);
        rd(3'd2, a); idle(20); rd(3'd2, b);
        check("R2 start counts", b, a + 10);
        wr(3'd0, 2'b10);
        rd(3'd2, a); idle(20); rd(3'd2, b);
        check("R2 stop holds", b, a);
        wr(3'd0, 2'b01);
        wr(3'd0, 2'b11);
        rd(3'd2, a); idle(20); rd(3'd2, b);
        check("R2 stop wins over start", b, a);
        wr(3'd0, 2'b01);
    endtask

    task automatic t_sync;
        logic [DW-1:0] v;
        wr(3'd6, 2'b01);
        rd(3'd2, v); check("R4 sync zeroes low", v, 0);
        rd(3'd4, v); check("R4 sync zeroes high", v, 0);
        idle(40);
        rd(3'd2, v); check("R4 count after sync", v, 20);
    endtask

    task automatic t_prescale;
        logic [DW-1:0] v;
        wr(3'd1, 2'd2);
        rd(3'd1, v); check("R3 index readback", v, 2);
        wr(3'd6, 2'b01); idle(320);
        rd(3'd2, v); check("R3 divide by 32", v, 10);
        wr(3'd1, 2'd3);
        wr(3'd6, 2'b01); idle(1280);
        rd(3'd2, v); check("R3 divide by 128", v, 10);
        wr(3'd1, 2'd1);
        wr(3'd6, 2'b01); idle(80);
        rd(3'd2, v); check("R3 divide by 8", v, 10);
        wr(3'd1, 2'd0);
    endtask

    task automatic t_chain;
        logic [DW-1:0] v;
        wr(3'd5, 2'b01);
        rd(3'd5, v); check("R6 routing readback", v, 1);
        wr(3'd6, 2'b01);
        idle(255);
        rd(3'd2, v); check("R5 low below half", v, 127);
        check("R5 wave high below half", wave_out[0], 1);
        idle(1);
        check("R5 wave falls at half", wave_out[0], 0);
        idle(256);
        rd(3'd2, v); check("R7 low wraps to zero", v, 0);
        rd(3'd4, v); check("R6 high not yet advanced", v, 0);
        check("R5 wave rises at zero", wave_out[0], 1);
        idle(1);
        rd(3'd4, v); check("R6 high advances after edge", v, 1);
    endtask

    task automatic t_route_off;
        logic [DW-1:0] v;
        wr(3'd5, 2'b00);
        wr(3'd6, 2'b01);
        idle(600);
        rd(3'd2, v); check("R7 low keeps counting after wrap", v, 44);
        rd(3'd4, v); check("R6 unrouted high holds", v, 0);
    endtask

    task automatic t_monotonic;
        logic [DW-1:0] prev, ts;
        int bad;
        bad = 0;
        prev = '0;
        wr(3'd5, 2'b01);
        wr(3'd6, 2'b01);
        for (int i = 0; i < 1600; i++) begin
            read_ts(ts);
            if (ts < prev) bad++;
            prev = ts;
        end
        check("R8 retried reads never decrease", bad, 0);
        check("R8 high half reached", (ts >= 16'h0900) ? 1 : 0, 1);
    endtask

    task automatic t_wide;
        logic [DW-1:0] v;
        wr_w(3'd0, 2'b01);
        wr_w(3'd3, 2'b01);
        wr_w(3'd6, 2'b01);
        idle(600);
        rd_w(3'd2, v); check("R9 single wide channel", v, 300);
        rd_w(3'd4, v); check("R9 second channel reads zero", v, 0);
        check("R9 second wave low", wave_out_w[1], 0);
        check("R9 wave high below half", wave_out_w[0], 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_start_stop();
        t_sync();
        t_prescale();
        t_chain();
        t_route_off();
        t_monotonic();
        t_wide();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule